// File: doc/BRIEF.md
# Branch History Register Table

This block keeps the recent direction history of conditional branches as shift registers, for use by a downstream direction predictor. Each history register is `HIST_W` bits wide; when a branch resolves, its outcome enters at bit 0 and every older outcome moves up one position, with the oldest falling off the top.

A parameter selects one of two arrangements. The global arrangement holds a single register fed by every resolved branch, so its contents describe the path through the most recent branches. The local arrangement holds `2**IDX_W` registers selected by word-address bits of the branch PC, so each one follows only the branches that map to it.

The block has two independent ports. The read port is combinational: it takes a fetch PC and returns the current history of the selected register. The resolve port takes a valid strobe, a branch PC and its outcome, and shifts that outcome in on the next clock edge. Only conditional branches are expected to drive the resolve port. The reset input is asynchronous and active low; its release is synchronised inside the block.

Top module: `bhist_table`

## Requirements
- R1: On a resolve with `rs_valid` high, bit 0 of the selected register takes the outcome after the clock edge, with 1 for taken and 0 for not taken.
- R2: On the same edge, bit i of the selected register takes its previous bit i-1 for i from 1 to `HIST_W`-1, and the previous most significant bit is discarded.
- R3: With `HIST_W`=3 and a register starting at 000, the outcomes taken, taken, taken, not taken, taken, taken leave it at 001, 011, 111, 110, 101 and 011 in turn.
- R4: In local mode the register is selected by `pc[IDX_W+1:2]` on both ports, all other PC bits have no effect, and a resolve changes no register except the selected one.
- R5: In global mode both ports use the one register whatever the PC, so every resolved branch shifts into it.
- R6: `rd_hist` follows `rd_pc` in the same cycle; a read of the register being shifted in that cycle returns the value before the shift, and the new value appears after the clock edge.
- R7: While `rs_valid` is low, no register changes, whatever `rs_pc` and `rs_taken` are.
- R8: Reset clears every register to all zeros, and they stay zero until the first resolve after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| rd_pc | input | PC_W | PC whose history is requested |
| rd_hist | output | HIST_W | History of the register selected by `rd_pc` |
| rs_valid | input | 1 | A conditional branch resolves this cycle |
| rs_pc | input | PC_W | PC of the resolving branch |
| rs_taken | input | 1 | Outcome of the resolving branch, 1 for taken |

## Verification
On every cycle, assertions check that each register either takes the shifted value with the new outcome at bit 0, or holds when it is not the target. They also check that at most one register is written per cycle, exactly one when the strobe is high, and that a register leaves reset at zero. PC bit selection, aliasing of addresses that differ only outside the index field, and the exact six-step sequence can be shown only by the bench. The same holds for global mode ignoring the PC, and for a read returning the pre-shift value while a shift is in progress. The bench does this against a model of both a local and a global instance.

// File: rtl/bhist_pkg.sv
package bhist_pkg;

  typedef enum logic {
    HIST_GLOBAL = 1'b0,
    HIST_LOCAL  = 1'b1
  } hist_mode_e;

endpackage

// File: rtl/bhist_rst_sync.sv
module bhist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bhist_index.sv
module bhist_index
  import bhist_pkg::*;
#(
  parameter hist_mode_e MODE  = HIST_LOCAL,
  parameter int         PC_W  = 32,
  parameter int         IDX_W = 4,
  parameter int         SEL_W = 4
) (
  input  logic [PC_W-1:0]  pc,
  output logic [SEL_W-1:0] sel
);

  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;

  generate
    if (MODE == HIST_LOCAL) begin : g_local
      assign sel = pc[IDX_W+1:2];
    end else begin : g_global
      assign sel = '0;
    end
  endgenerate

endmodule

// File: rtl/bhist_wr_dec.sv
module bhist_wr_dec #(
  parameter int ENTRIES = 16,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               valid,
  input  logic [SEL_W-1:0]   sel,
  output logic [ENTRIES-1:0] wr_en
);

  always_comb begin
    wr_en = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid && (sel == SEL_W'(i))) begin
        wr_en[i] = 1'b1;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_ni)
    valid |-> ($countones(wr_en) == 1)) else $error("AST_ONE_TARGET"); // R4

  AST_NO_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid |-> (wr_en == '0)) else $error("AST_NO_TARGET_IDLE"); // R7

endmodule

// File: rtl/bhist_cell.sv
module bhist_cell #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic              taken,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (en) begin
      hist_d = {hist_q[HIST_W-2:0], taken};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist = hist_q;

  AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (!rst_ni)
    en |=> (hist_q[0] == $past(taken))) else $error("AST_NEWEST_BIT"); // R1

  AST_AGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_ni)
    en |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))) else $error("AST_AGE_SHIFT"); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> $stable(hist_q)) else $error("AST_HOLD_IDLE"); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_ni) |-> (hist_q == '0)) else $error("AST_RESET_CLEAR"); // R8

endmodule

// File: rtl/bhist_table.sv
module bhist_table
  import bhist_pkg::*;
#(
  parameter hist_mode_e MODE   = HIST_LOCAL,
  parameter int         PC_W   = 32,
  parameter int         IDX_W  = 4,
  parameter int         HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken
);

  localparam int ENTRIES = (MODE == HIST_LOCAL) ? (1 << IDX_W) : 1;
  localparam int SEL_W   = (MODE == HIST_LOCAL) ? IDX_W : 1;

  logic              rst_sync_n;
  logic [SEL_W-1:0]  rd_sel;
  logic [SEL_W-1:0]  rs_sel;
  logic [ENTRIES-1:0] wr_en;
  logic [HIST_W-1:0] hist_arr [ENTRIES];

  bhist_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bhist_index #(
    .MODE  (MODE),
    .PC_W  (PC_W),
    .IDX_W (IDX_W),
    .SEL_W (SEL_W)
  ) u_rd_index (
    .pc  (rd_pc),
    .sel (rd_sel)
  );

  bhist_index #(
    .MODE  (MODE),
    .PC_W  (PC_W),
    .IDX_W (IDX_W),
    .SEL_W (SEL_W)
  ) u_rs_index (
    .pc  (rs_pc),
    .sel (rs_sel)
  );

  bhist_wr_dec #(
    .ENTRIES (ENTRIES),
    .SEL_W   (SEL_W)
  ) u_wr_dec (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .valid  (rs_valid),
    .sel    (rs_sel),
    .wr_en  (wr_en)
  );

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      bhist_cell #(
        .HIST_W (HIST_W)
      ) u_cell (
        .clk    (clk),
        .rst_ni (rst_sync_n),
        .en     (wr_en[e]),
        .taken  (rs_taken),
        .hist   (hist_arr[e])
      );
    end
  endgenerate

  always_comb begin
    rd_hist = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_hist = hist_arr[i];
      end
    end
  end

  AST_READ_SAME_AS_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_valid && (rd_sel == rs_sel)) |=> (rd_hist[0] == $past(rs_taken)) || (rd_sel != $past(rd_sel)))
    else $error("AST_READ_SAME_AS_SHIFT"); // R6

endmodule

// File: tb/bhist_table_bench.sv
`timescale 1ns/1ps
module bhist_table_bench;
  import bhist_pkg::*;

  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 8;
  localparam int GH_W   = 3;

  typedef struct {
    bit           glb;
    logic [7:0]   exp;
    string        tag;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic [PC_W-1:0]   rd_pc;
  logic [HIST_W-1:0] rd_hist;
  logic [GH_W-1:0]   rd_hist_g;
  logic              rs_valid;
  logic [PC_W-1:0]   rs_pc;
  logic              rs_taken;

  int   n_cmp;
  int   n_bad;
  bit   done;
  exp_t sb [$];

  logic [HIST_W-1:0] loc_m [16];
  logic [GH_W-1:0]   glb_m;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bhist_table #(.MODE(HIST_LOCAL), .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_bhist_table (
    .clk(clk), .rst_n(rst_n), .rd_pc(rd_pc), .rd_hist(rd_hist),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

  bhist_table #(.MODE(HIST_GLOBAL), .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(GH_W)) u_bhist_table_glb (
    .clk(clk), .rst_n(rst_n), .rd_pc(rd_pc), .rd_hist(rd_hist_g),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

  // monitor: compares every pending expectation at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      logic [7:0] got;
      it  = sb.pop_front();
      got = it.glb ? {5'b0, rd_hist_g} : rd_hist;
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic push_both(input logic [PC_W-1:0] pc, input string tag);
    exp_t a;
    exp_t b;
    a.glb = 1'b0; a.exp = loc_m[idx_of(pc)]; a.tag = {tag, " local"};
    b.glb = 1'b1; b.exp = {5'b0, glb_m};     b.tag = {tag, " global"};
    sb.push_back(a);
    sb.push_back(b);
  endtask

  // read check: drive rd_pc, expectation compared at next negedge
  task automatic read_chk(input logic [PC_W-1:0] pc, input string tag);
    rd_pc = pc;
    push_both(pc, tag);
    @(posedge clk); #1;
  endtask

  // resolve: reads the same PC in the shifting cycle (pre-shift value, R6)
  task automatic resolve(input logic [PC_W-1:0] pc, input logic tk, input string tag);
    rs_valid = 1'b1;
    rs_pc    = pc;
    rs_taken = tk;
    rd_pc    = pc;
    push_both(pc, {tag, " R6 pre-shift"});
    @(posedge clk);
    loc_m[idx_of(pc)] = {loc_m[idx_of(pc)][HIST_W-2:0], tk};
    glb_m             = {glb_m[GH_W-2:0], tk};
    #1;
    rs_valid = 1'b0;
  endtask

  task automatic glb_exact(input logic [PC_W-1:0] pc, input logic [GH_W-1:0] e, input string tag);
    exp_t a;
    rd_pc = pc;
    a.glb = 1'b1; a.exp = {5'b0, e}; a.tag = tag;
    sb.push_back(a);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [GH_W-1:0] seq_e [6];
    logic            seq_t [6];
    n_cmp = 0; n_bad = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) loc_m[i] = '0;
    glb_m = '0;
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rd_pc = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: registers are zero while reset is held, even with a strobe present
    rs_valid = 1'b1; rs_taken = 1'b1; rs_pc = 32'h0000_0004;
    read_chk(32'h0000_0004, "R8 in reset");
    rs_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) read_chk(PC_W'(i * 4), "R8 after release");

    // R3 / R5: exact sequence on the 3-bit global register, PC varied every step
    seq_t[0] = 1; seq_t[1] = 1; seq_t[2] = 1; seq_t[3] = 0; seq_t[4] = 1; seq_t[5] = 1;
    seq_e[0] = 3'b001; seq_e[1] = 3'b011; seq_e[2] = 3'b111;
    seq_e[3] = 3'b110; seq_e[4] = 3'b101; seq_e[5] = 3'b011;
    for (int s = 0; s < 6; s++) begin
      resolve(PC_W'(32'h1000_0000 + s * 36), seq_t[s], "R3 R5 step");
      glb_exact(PC_W'(32'hABCD_0000 + s * 4), seq_e[s], "R3 sequence");
    end

    // R1 / R2: long pattern on one local entry so the oldest bits fall off
    for (int s = 0; s < 11; s++) begin
      resolve(32'h0000_0108, (s % 3) != 1, "R1 R2 pattern");
      read_chk(32'h0000_0108, "R1 R2 after shift");
    end

    // R4: aliases differing outside pc[5:2] share one entry; neighbours untouched
    resolve(32'h0000_0100, 1'b1, "R4 base");
    resolve(32'h0000_0103, 1'b0, "R4 low bits alias");
    resolve(32'h7FF0_0100, 1'b1, "R4 high bits alias");
    read_chk(32'h0000_0100, "R4 aliased entry");
    read_chk(32'h0000_0104, "R4 neighbour unchanged");
    read_chk(32'h0000_013C, "R4 top entry unchanged");

    // R7: outcome and PC toggle with strobe low, nothing may move
    for (int s = 0; s < 6; s++) begin
      rs_valid = 1'b0; rs_pc = PC_W'(s * 4); rs_taken = s[0];
      @(posedge clk); #1;
    end
    for (int i = 0; i < 16; i++) read_chk(PC_W'(i * 4 + 32'h200), "R7 idle strobe");

    // R6: read port follows rd_pc in the same cycle across all entries
    for (int i = 15; i >= 0; i--) read_chk(PC_W'(i * 4), "R6 combinational read");

    // R1 R2 R4 R5: pseudo-random mix of PCs and outcomes
    lfsr = 16'hACE1;
    for (int s = 0; s < 300; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      resolve({lfsr, lfsr[7:0], lfsr[15:8]}, lfsr[3], "R1 R4 R5 mix");
      if (s % 5 == 0) read_chk({16'h0, lfsr ^ 16'h5A5A}, "R4 R5 mix read");
    end
    rs_valid = 1'b0;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule